// File: doc/BRIEF.md
# Cascaded Event Interrupt Multiplexer

This block gathers up to 96 single-bit event sources into three 32-bit pending words and drives three level-sensitive interrupt lines from them. An event is raised with a set strobe and a 7-bit event number. It is retired with a clear strobe and a 7-bit number. Each interrupt line has three mask words of its own, one for each pending word. A line is high while any pending bit under any of its masks is set.

Word zero doubles as a summary word. Two of its bits mirror activity in words one and two. Any event raised in word one also raises bit 30 of word zero, and any event raised in word two also raises bit 31. When a clear empties word one or word two, the matching summary bit drops as well. Software can therefore service the interrupt with a single mask on word zero and descend into the deeper word only when its summary bit is set.

The lines are registered. They follow every set, clear and mask write one clock later, so a mask change alone can raise or drop a line. Software reads all pending bits from a flat bus whose bit index equals the event number. It reads any mask word through an index port.

Top module: `evt_irq_mux`

## Requirements
- R1: An event number splits into a word field (bits 6:5) and a bit field (bits 4:0). A set strobe for an event below 96 makes `pend_o[num]` read 1 after the next rising edge.
- R2: A set in word 1 (events 32 to 63) also sets `pend_o[30]`. A set in word 2 (events 64 to 95) also sets `pend_o[31]`, on the same edge.
- R3: A clear strobe makes `pend_o[num]` read 0 after the next edge. If that leaves word 1 all zero, bit 30 drops too, and if it leaves word 2 all zero, bit 31 drops too. While the word still holds any set bit, its summary bit stays.
- R4: When a set and a clear target the same bit in the same cycle, the bit ends set. This also holds when the set reaches the bit through the summary rule of R2.
- R5: After every rising edge out of reset, `irq_o[j]` equals the OR, over words w = 0..2, of (pending word w AND mask slot 3*j + w). It changes one edge after the stimulus that causes the change.
- R6: A write with `msk_wr_i` high loads `msk_wr_data_i` into slot `msk_wr_idx_i`, where slot = 3*line + word. Slot indices 9 to 15 store nothing. `msk_rd_data_o` shows slot `msk_rd_idx_i` combinationally, and reads zero for indices 9 to 15.
- R7: A mask write with no set or clear in the same cycle re-evaluates every line. A line can rise or fall on the new masks alone, without any event activity.
- R8: While `rst_n` is low, all pending bits, all mask slots and all interrupt lines are zero.
- R9: Set or clear strobes whose word field is 3 (events 96 to 127) change no pending bit and no interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set_i | input | 1 | Raise-event strobe |
| ev_set_num_i | input | 7 | Event number to raise |
| ev_clr_i | input | 1 | Clear-event strobe |
| ev_clr_num_i | input | 7 | Event number to clear |
| msk_wr_i | input | 1 | Mask slot write enable |
| msk_wr_idx_i | input | 4 | Mask slot to write (3*line + word) |
| msk_wr_data_i | input | 32 | Mask write data |
| msk_rd_idx_i | input | 4 | Mask slot to read |
| msk_rd_data_o | output | 32 | Contents of the selected mask slot |
| pend_o | output | 96 | All pending bits; bit index equals event number |
| irq_o | output | 3 | Interrupt lines (0 = A, 1 = B, 2 = C) |

## Verification
The main function is tried under three patterns.

A single-event sweep raises and then clears each of the 128 event numbers in turn, with masks that cover different halves, alternate bits and the summary bits. This isolates the word and bit decode, the summary bit behaviour and the ignored word field. An accumulate-and-drain pattern raises all 96 events and then clears them in reverse order. It separates a summary bit that holds while its word still has members from one that drops when the word empties. Directed same-cycle set/clear pairs and mask-only write sequences then distinguish set priority, including priority over a summary-bit clear, and show lines moving on mask changes alone.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int unsigned EV_WORD_BITS_DFLT = 32;
    localparam int unsigned EV_WORDS_DFLT     = 3;
    localparam int unsigned EV_LINES_DFLT     = 3;

    // Position in word zero of the summary bit for deeper word w (w >= 1).
    function automatic int unsigned summary_pos(int unsigned wbits, int unsigned nwords,
                                                int unsigned w);
        return wbits - nwords + w;
    endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
    parameter int WBITS  = 32,
    parameter int NWORDS = 3,
    parameter int NUMW   = 7
) (
    input  logic                          vld,
    input  logic [NUMW-1:0]               num,
    output logic [NWORDS-1:0][WBITS-1:0]  hot,
    output logic [NWORDS-1:0]             word_hit
);
    localparam int LOGW = $clog2(WBITS);
    localparam int SELW = NUMW - LOGW;

    logic [SELW-1:0] wsel;
    logic [LOGW-1:0] bsel;

    assign wsel = num[NUMW-1:LOGW];
    assign bsel = num[LOGW-1:0];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign word_hit[w] = vld && (wsel == SELW'(w));
        assign hot[w]      = word_hit[w] ? (WBITS'(1) << bsel) : '0;
    end
endmodule

// File: rtl/evt_pending_bank.sv
module evt_pending_bank
    import evt_irq_pkg::*;
#(
    parameter int WBITS  = 32,
    parameter int NWORDS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NWORDS-1:0][WBITS-1:0]  set_hot,
    input  logic [NWORDS-1:0]             set_hit,
    input  logic [NWORDS-1:0][WBITS-1:0]  clr_hot,
    input  logic [NWORDS-1:0]             clr_hit,
    output logic [NWORDS-1:0][WBITS-1:0]  pend_q,
    output logic [NWORDS-1:0][WBITS-1:0]  pend_nxt
);
    logic [NWORDS-1:0][WBITS-1:0] merged;
    logic [WBITS-1:0]             sum_set;
    logic [WBITS-1:0]             sum_clr;

    // Clear first, then set, so a set always wins on a shared bit.
    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            merged[w] = (pend_q[w] & ~clr_hot[w]) | set_hot[w];
        end
    end

    // Summary bits in word zero for each deeper word.
    always_comb begin
        sum_set = '0;
        sum_clr = '0;
        for (int w = 1; w < NWORDS; w++) begin
            if (set_hit[w]) begin
                sum_set[summary_pos(WBITS, NWORDS, w)] = 1'b1;
            end
            if (clr_hit[w] && (merged[w] == '0)) begin
                sum_clr[summary_pos(WBITS, NWORDS, w)] = 1'b1;
            end
        end
    end

    always_comb begin
        pend_nxt    = merged;
        pend_nxt[0] = (pend_q[0] & ~clr_hot[0] & ~sum_clr) | set_hot[0] | sum_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
    parameter int WBITS = 32,
    parameter int NSLOT = 9,
    parameter int IDXW  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDXW-1:0]              wr_idx,
    input  logic [WBITS-1:0]             wr_data,
    input  logic [IDXW-1:0]              rd_idx,
    output logic [WBITS-1:0]             rd_data,
    output logic [NSLOT-1:0][WBITS-1:0]  mask_q,
    output logic [NSLOT-1:0][WBITS-1:0]  mask_nxt
);
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            mask_nxt[s] = (we && (wr_idx == IDXW'(s))) ? wr_data : mask_q[s];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_idx == IDXW'(s)) begin
                rd_data = mask_q[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_nxt;
        end
    end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
    parameter int WBITS  = 32,
    parameter int NWORDS = 3,
    parameter int NOUT   = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NWORDS-1:0][WBITS-1:0]       pend_nxt,
    input  logic [NOUT*NWORDS-1:0][WBITS-1:0]  mask_nxt,
    output logic [NOUT-1:0]                    irq_q
);
    logic [NOUT-1:0][WBITS-1:0] acc;
    logic [NOUT-1:0]            lvl;

    always_comb begin
        for (int j = 0; j < NOUT; j++) begin
            acc[j] = '0;
            for (int w = 0; w < NWORDS; w++) begin
                acc[j] = acc[j] | (pend_nxt[w] & mask_nxt[j*NWORDS + w]);
            end
            lvl[j] = |acc[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= lvl;
        end
    end
endmodule

// File: rtl/evt_irq_mux.sv
module evt_irq_mux
    import evt_irq_pkg::*;
#(
    parameter int WBITS  = EV_WORD_BITS_DFLT,
    parameter int NWORDS = EV_WORDS_DFLT,
    parameter int NOUT   = EV_LINES_DFLT,
    localparam int NUMW  = $clog2(WBITS) + $clog2(NWORDS),
    localparam int NSLOT = NOUT * NWORDS,
    localparam int IDXW  = $clog2(NSLOT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_set_i,
    input  logic [NUMW-1:0]          ev_set_num_i,
    input  logic                     ev_clr_i,
    input  logic [NUMW-1:0]          ev_clr_num_i,
    input  logic                     msk_wr_i,
    input  logic [IDXW-1:0]          msk_wr_idx_i,
    input  logic [WBITS-1:0]         msk_wr_data_i,
    input  logic [IDXW-1:0]          msk_rd_idx_i,
    output logic [WBITS-1:0]         msk_rd_data_o,
    output logic [NWORDS*WBITS-1:0]  pend_o,
    output logic [NOUT-1:0]          irq_o
);
    logic [NWORDS-1:0][WBITS-1:0] set_hot;
    logic [NWORDS-1:0][WBITS-1:0] clr_hot;
    logic [NWORDS-1:0]            set_hit;
    logic [NWORDS-1:0]            clr_hit;
    logic [NWORDS-1:0][WBITS-1:0] pend_q;
    logic [NWORDS-1:0][WBITS-1:0] pend_nxt;
    logic [NSLOT-1:0][WBITS-1:0]  mask_q;
    logic [NSLOT-1:0][WBITS-1:0]  mask_nxt;

    evt_decode #(.WBITS(WBITS), .NWORDS(NWORDS), .NUMW(NUMW)) u_set_dec (
        .vld      (ev_set_i),
        .num      (ev_set_num_i),
        .hot      (set_hot),
        .word_hit (set_hit)
    );

    evt_decode #(.WBITS(WBITS), .NWORDS(NWORDS), .NUMW(NUMW)) u_clr_dec (
        .vld      (ev_clr_i),
        .num      (ev_clr_num_i),
        .hot      (clr_hot),
        .word_hit (clr_hit)
    );

    evt_pending_bank #(.WBITS(WBITS), .NWORDS(NWORDS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hot  (set_hot),
        .set_hit  (set_hit),
        .clr_hot  (clr_hot),
        .clr_hit  (clr_hit),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt)
    );

    evt_mask_bank #(.WBITS(WBITS), .NSLOT(NSLOT), .IDXW(IDXW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (msk_wr_i),
        .wr_idx   (msk_wr_idx_i),
        .wr_data  (msk_wr_data_i),
        .rd_idx   (msk_rd_idx_i),
        .rd_data  (msk_rd_data_o),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    evt_irq_reduce #(.WBITS(WBITS), .NWORDS(NWORDS), .NOUT(NOUT)) u_reduce (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_nxt),
        .mask_nxt (mask_nxt),
        .irq_q    (irq_o)
    );

    assign pend_o = pend_q;
endmodule

// File: rtl/evt_irq_mux_chk.sv
module evt_irq_mux_chk #(
    parameter int WBITS  = 32,
    parameter int NWORDS = 3,
    parameter int NOUT   = 3,
    parameter int NUMW   = 7
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               ev_set_i,
    input logic [NUMW-1:0]                    ev_set_num_i,
    input logic                               ev_clr_i,
    input logic [NUMW-1:0]                    ev_clr_num_i,
    input logic                               msk_wr_i,
    input logic [NWORDS*WBITS-1:0]            pend_o,
    input logic [NOUT-1:0]                    irq_o,
    input logic [NOUT*NWORDS-1:0][WBITS-1:0]  mask_q
);
    localparam int LOGW = $clog2(WBITS);
    localparam int SELW = NUMW - LOGW;

    logic [NOUT-1:0] exp_irq;
    logic            set_in_rng;
    logic            clr_in_rng;
    logic            clr_contested;
    logic [NUMW-1:0] prev_set_num;
    logic [NUMW-1:0] prev_clr_num;

    assign set_in_rng = int'(ev_set_num_i) < NWORDS * WBITS;
    assign clr_in_rng = int'(ev_clr_num_i) < NWORDS * WBITS;

    always_comb begin
        for (int j = 0; j < NOUT; j++) begin
            exp_irq[j] = 1'b0;
            for (int w = 0; w < NWORDS; w++) begin
                exp_irq[j] = exp_irq[j] | (|(pend_o[w*WBITS +: WBITS] & mask_q[j*NWORDS + w]));
            end
        end
    end

    always_comb begin
        clr_contested = ev_set_i && (ev_set_num_i == ev_clr_num_i);
        for (int w = 1; w < NWORDS; w++) begin
            if (ev_set_i && (ev_set_num_i[NUMW-1:LOGW] == SELW'(w)) &&
                (int'(ev_clr_num_i) == WBITS - NWORDS + w)) begin
                clr_contested = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_set_num <= '0;
            prev_clr_num <= '0;
        end else begin
            prev_set_num <= ev_set_num_i;
            prev_clr_num <= ev_clr_num_i;
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set_i && set_in_rng |=> pend_o[prev_set_num]); // R1

    for (genvar w = 1; w < NWORDS; w++) begin : g_sum
        AST_SUMMARY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set_i && (ev_set_num_i[NUMW-1:LOGW] == SELW'(w)) |=> pend_o[WBITS-NWORDS+w]); // R2
    end

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clr_i && clr_in_rng && !clr_contested |=> !pend_o[prev_clr_num]); // R3

    AST_SET_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set_i && ev_clr_i && set_in_rng && (ev_set_num_i == ev_clr_num_i)
        |=> pend_o[prev_set_num]); // R4

    AST_LINE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == exp_irq); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_set_i && !ev_clr_i && !msk_wr_i |=> $stable(irq_o) && $stable(pend_o)); // R7
endmodule

bind evt_irq_mux evt_irq_mux_chk #(
    .WBITS(WBITS), .NWORDS(NWORDS), .NOUT(NOUT), .NUMW(NUMW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_set_i     (ev_set_i),
    .ev_set_num_i (ev_set_num_i),
    .ev_clr_i     (ev_clr_i),
    .ev_clr_num_i (ev_clr_num_i),
    .msk_wr_i     (msk_wr_i),
    .pend_o       (pend_o),
    .irq_o        (irq_o),
    .mask_q       (mask_q)
);

// File: tb/evt_irq_mux_test.sv
`timescale 1ns/1ps
module evt_irq_mux_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_set_i = 1'b0;
    logic [6:0]  ev_set_num_i = '0;
    logic        ev_clr_i = 1'b0;
    logic [6:0]  ev_clr_num_i = '0;
    logic        msk_wr_i = 1'b0;
    logic [3:0]  msk_wr_idx_i = '0;
    logic [31:0] msk_wr_data_i = '0;
    logic [3:0]  msk_rd_idx_i = '0;
    logic [31:0] msk_rd_data_o;
    logic [95:0] pend_o;
    logic [2:0]  irq_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] mp [3];
    logic [31:0] mm [9];

    evt_irq_mux uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_set_i      (ev_set_i),
        .ev_set_num_i  (ev_set_num_i),
        .ev_clr_i      (ev_clr_i),
        .ev_clr_num_i  (ev_clr_num_i),
        .msk_wr_i      (msk_wr_i),
        .msk_wr_idx_i  (msk_wr_idx_i),
        .msk_wr_data_i (msk_wr_data_i),
        .msk_rd_idx_i  (msk_rd_idx_i),
        .msk_rd_data_o (msk_rd_data_o),
        .pend_o        (pend_o),
        .irq_o         (irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] exp_lines();
        logic [2:0] r;
        for (int j = 0; j < 3; j++) begin
            r[j] = |((mp[0] & mm[3*j]) | (mp[1] & mm[3*j+1]) | (mp[2] & mm[3*j+2]));
        end
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [95:0] ep;
        logic [2:0]  ei;
        ep = {mp[2], mp[1], mp[0]};
        ei = exp_lines();
        n_vec++;
        if (pend_o !== ep) begin
            n_bad++;
            $display("FAIL %s pending: actual %h expected %h", tag, pend_o, ep);
        end
        n_vec++;
        if (irq_o !== ei) begin
            n_bad++;
            $display("FAIL %s lines: actual %b expected %b", tag, irq_o, ei);
        end
    endtask

    // One clocked stimulus; the model is updated from the requirements.
    task automatic step(input bit sv, input int sn, input bit cv, input int cn,
                        input bit mw, input int mi, input logic [31:0] md, input string tag);
        int sw, sb, cw, cb;
        logic [31:0] post;
        @(negedge clk);
        ev_set_i = sv; ev_set_num_i = 7'(sn);
        ev_clr_i = cv; ev_clr_num_i = 7'(cn);
        msk_wr_i = mw; msk_wr_idx_i = 4'(mi); msk_wr_data_i = md;
        sw = sn / 32; sb = sn % 32; cw = cn / 32; cb = cn % 32;
        if (cv && cw < 3) mp[cw][cb] = 1'b0;
        if (cv && (cw == 1 || cw == 2)) begin
            post = mp[cw];
            if (sv && sw == cw) post[sb] = 1'b1;
            if (post == '0) mp[0][29+cw] = 1'b0;
        end
        if (sv && sw < 3) begin
            mp[sw][sb] = 1'b1;
            if (sw == 1) mp[0][30] = 1'b1;
            if (sw == 2) mp[0][31] = 1'b1;
        end
        if (mw && mi < 9) mm[mi] = md;
        @(negedge clk);
        ev_set_i = 1'b0; ev_clr_i = 1'b0; msk_wr_i = 1'b0;
        compare(tag);
    endtask

    task automatic check_masks(input string tag);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            msk_rd_idx_i = 4'(i);
            #1;
            e = (i < 9) ? mm[i] : 32'h0;
            n_vec++;
            if (msk_rd_data_o !== e) begin
                n_bad++;
                $display("FAIL %s mask slot %0d: actual %h expected %h", tag, i, msk_rd_data_o, e);
            end
        end
    endtask

    task automatic set_masks(input logic [31:0] v [9]);
        for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, i, v[i], "R6 load");
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] mv [9];
        for (int i = 0; i < 3; i++) mp[i] = '0;
        for (int i = 0; i < 9; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        compare("R8 reset");
        check_masks("R8 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R6: every slot index, including the ignored ones.
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, i, 32'h1357_9BDF ^ (32'h0101_0101 * i), "R6 write");
        check_masks("R6 readback");

        // Sweep masks: A low half of word 0, B alternate bits of word 1,
        // C summary bit 31 plus bit 0 of word 2.
        mv = '{32'h0000_FFFF, 32'h0, 32'h0, 32'h0, 32'hAAAA_AAAA, 32'h0,
               32'h8000_0000, 32'h0, 32'h0000_0001};
        set_masks(mv);

        // R1 R2 R3 R5 R9: each event alone, raised then cleared.
        for (int e = 0; e < 128; e++) begin
            step(1, e, 0, 0, 0, 0, 0, "R1 R2 R9 single set");
            step(0, 0, 1, e, 0, 0, 0, "R3 R5 single clear");
        end

        // R3: accumulate all events, drain in reverse; summary holds until empty.
        for (int e = 0; e < 96; e++) step(1, e, 0, 0, 0, 0, 0, "R2 R5 accumulate");
        for (int e = 95; e >= 0; e--) step(0, 0, 1, e, 0, 0, 0, "R3 R5 drain");

        // R4: set priority.
        step(1, 40, 1, 40, 0, 0, 0, "R4 same bit");
        step(1, 33, 1, 40, 0, 0, 0, "R3 word not empty");
        step(0, 0, 1, 40, 0, 0, 0, "R3 word still not empty");
        step(1, 5, 1, 33, 0, 0, 0, "R3 word empties");
        step(1, 70, 1, 31, 0, 0, 0, "R4 summary set beats clear");
        step(1, 31, 1, 70, 0, 0, 0, "R4 direct set beats summary clear");
        step(0, 0, 1, 31, 0, 0, 0, "R3 direct clear summary");
        step(0, 0, 1, 5, 0, 0, 0, "R3 cleanup");

        // R7: lines move on mask writes alone.
        for (int i = 0; i < 9; i++) mv[i] = '0;
        set_masks(mv);
        step(1, 70, 0, 0, 0, 0, 0, "R7 masked set");
        step(0, 0, 0, 0, 1, 5, 32'h0000_0040, "R7 unmask B rises");
        step(0, 0, 0, 0, 1, 6, 32'h8000_0000, "R7 unmask C rises");
        step(0, 0, 0, 0, 1, 5, 32'h0, "R7 remask B falls");
        step(0, 0, 0, 0, 1, 12, 32'hFFFF_FFFF, "R7 R6 unused slot no effect");
        step(0, 0, 0, 0, 1, 6, 32'h0, "R7 remask C falls");
        step(0, 0, 0, 0, 1, 0, 32'hC000_0000, "R7 unmask A summary");

        // R9: word field 3 ignored, with state present.
        step(1, 102, 0, 0, 0, 0, 0, "R9 set ignored");
        step(0, 0, 1, 102, 0, 0, 0, "R9 clear ignored");
        step(0, 0, 1, 70, 0, 0, 0, "R3 R5 final clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule